// File: doc/BRIEF.md
# Cell header-check slot reservation and insertion

This block sits in a transmit path that carries fixed-size cells over a 32-bit word bus. Cells arrive as thirteen words, 52 bytes, with the one-byte header check missing. The block opens a one-byte slot after each cell's 4-byte header and fills it with a check byte supplied from outside. The result is a gapless stream of 53-byte cells on the same 32-bit bus.

Because 53 is not a multiple of four, successive cells start in successive byte lanes. A six-state one-hot sequencer picks the byte shift that is applied between a "new" word register and a "previous" word register. One pass of the sequencer lasts 53 enabled cycles. Four cells need 53 output words but only 52 input words, so once per pass the block raises `jerk_o` for one slot. While `jerk_o` is high the upstream stage must hold its word.

`en_i` is the pipeline advance. When it is low, every register in the block holds its value.

Top module: `hec_slot_ins`

## Requirements
- R1: While `rst_ni` is low, `word_o` is zero and `jerk_o` is low. The word produced on the first enabled cycle after reset is zero.
- R2: Output bytes leave most significant byte first (`[31:24]` is the earliest byte in a word), with no gaps. For each cell the order is: its 4 header bytes, then the check byte, then its 48 payload bytes. Four cells take exactly 53 output words.
- R3: The first input word accepted after reset (the header of cell 0) appears unchanged on `word_o` after the second enabled clock edge.
- R4: `jerk_o` is high for exactly one slot in every 53 enabled cycles. It is high first during the 42nd enabled cycle after reset (0-based count 41). A word on `data_i` is not taken while `jerk_o` is high.
- R5: `hec_i` is taken alongside `data_i`: it must carry the check byte of the cell that the word on `data_i` belongs to. Within each group of four cells, the check byte lands in lane 0, 1, 2 and 3 in turn (lane 0 = `[31:24]`). The lane pointer advances in the same cycle that the byte is inserted.
- R6: When `en_i` is low, `word_o` keeps its value and no input word is taken.
- R7: Each accepted word moves from the new register to the previous register. In the jerk slot both registers hold, so the next output word is the held new word, unshifted.
- R8: The shift sequencer is one-hot at all times. Its states last 13, 13, 1, 12, 1 and 13 enabled cycles (shift 0, shift 1, shift 1-to-2, shift 2, shift 2-to-3, shift 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Pipeline advance |
| data_i | input | 32 | Cell word without check byte |
| hec_i | input | 8 | Check byte of the cell that owns data_i |
| word_o | output | 32 | Realigned word with check byte in place |
| jerk_o | output | 1 | Hold request to upstream, one slot per 53 |

## Verification
The hardest case to reach is the jerk slot in combination with a stalled pipeline. This is the moment the check byte goes into lane 3 and the new word must be reused. If `en_i` drops exactly there, the held word and the lane pointer must both survive the idle cycles. The stimulus first runs at full rate so that every state boundary of the first group is crossed cleanly. It then inserts random idle cycles and deliberately pulls `en_i` low in one jerk slot. Six groups of cells are sent with incrementing, saturated, alternating and random bytes.

// File: rtl/hec_slot_pkg.sv
package hec_slot_pkg;
  localparam int LANES = 4;
  localparam int NST   = 6;
  localparam int ST_S0  = 0;
  localparam int ST_S1  = 1;
  localparam int ST_S12 = 2;
  localparam int ST_S2  = 3;
  localparam int ST_S23 = 4;
  localparam int ST_S3  = 5;

  function automatic int dwell_f(int st, int cw);
    case (st)
      ST_S12, ST_S23: return 1;
      ST_S2:          return cw - 1;
      default:        return cw;
    endcase
  endfunction

  // bytes of delay applied to a given output lane in a given state
  function automatic int lane_shift_f(int st, int lane);
    case (st)
      ST_S0:   return 0;
      ST_S1:   return 1;
      ST_S12:  return (lane == 0) ? 1 : 2;
      ST_S2:   return 2;
      ST_S23:  return (lane < 2) ? 2 : 3;
      default: return 3;
    endcase
  endfunction
endpackage

// File: rtl/hec_shift_seq.sv
module hec_shift_seq
  import hec_slot_pkg::*;
#(
  parameter int CELL_WORDS = 13
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  output logic [NST-1:0] st_o,
  output logic           hec_now_o,
  output logic           jerk_o
);
  localparam int CNT_W = $clog2(CELL_WORDS);

  logic [NST-1:0]   st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_last;
  logic             last;

  always_comb begin
    cnt_last = '0;
    for (int i = 0; i < NST; i++)
      if (st_q[i]) cnt_last = CNT_W'(dwell_f(i, CELL_WORDS) - 1);
  end

  assign last = (cnt_q == cnt_last);

  // reset lands two slots before the end of shift 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= NST'(1);
      cnt_q <= CNT_W'(CELL_WORDS - 2);
    end else if (en_i) begin
      if (last) begin
        st_q  <= {st_q[NST-2:0], st_q[NST-1]};
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign st_o      = st_q;
  assign jerk_o    = st_q[ST_S3] && last;
  assign hec_now_o = ((st_q[ST_S1] || st_q[ST_S12] || st_q[ST_S23]) && (cnt_q == '0))
                   || (st_q[ST_S3] && last);
endmodule

// File: rtl/hec_word_pair.sv
module hec_word_pair #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] new_o,
  output logic [W-1:0] prev_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      new_o  <= '0;
      prev_o <= '0;
    end else if (load_i) begin
      new_o  <= data_i;
      prev_o <= new_o;
    end
  end
endmodule

// File: rtl/hec_lane_ctr.sv
module hec_lane_ctr #(
  parameter int LW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  output logic [LW-1:0] lane_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     lane_o <= '0;
    else if (step_i) lane_o <= lane_o + 1'b1;
  end
endmodule

// File: rtl/hec_byte_mux.sv
module hec_byte_mux
  import hec_slot_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0]   new_i,
  input  logic [W-1:0]   prev_i,
  input  logic [NST-1:0] st_i,
  input  logic [7:0]     hec_i,
  input  logic           hec_now_i,
  input  logic [1:0]     lane_i,
  output logic [W-1:0]   word_o
);
  int st_idx;

  always_comb begin
    st_idx = 0;
    for (int i = 0; i < NST; i++)
      if (st_i[i]) st_idx = i;
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_b;
    int         sh;
    always_comb begin
      sh = lane_shift_f(st_idx, l);
      if (hec_now_i && (lane_i == 2'(l)))
        lane_b = hec_i;
      else if (sh <= l)
        lane_b = new_i[(LANES-1-(l-sh))*8 +: 8];
      else
        lane_b = prev_i[(sh-l-1)*8 +: 8];
    end
    assign word_o[(LANES-1-l)*8 +: 8] = lane_b;
  end
endmodule

// File: rtl/hec_slot_ins.sv
module hec_slot_ins
  import hec_slot_pkg::*;
#(
  parameter int CELL_WORDS = 13
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        en_i,
  input  logic [31:0] data_i,
  input  logic [7:0]  hec_i,
  output logic [31:0] word_o,
  output logic        jerk_o
);
  localparam int W = LANES * 8;

  logic [NST-1:0] st_w;
  logic           hec_now_w;
  logic           jerk_w;
  logic           load_w;
  logic [W-1:0]   new_w;
  logic [W-1:0]   prev_w;
  logic [1:0]     lane_w;
  logic [W-1:0]   mux_w;
  logic [W-1:0]   word_q;

  hec_shift_seq #(.CELL_WORDS(CELL_WORDS)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en_i),
    .st_o      (st_w),
    .hec_now_o (hec_now_w),
    .jerk_o    (jerk_w)
  );

  assign load_w = en_i && !jerk_w;

  hec_word_pair #(.W(W)) u_pair (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load_w),
    .data_i (data_i),
    .new_o  (new_w),
    .prev_o (prev_w)
  );

  hec_lane_ctr #(.LW(2)) u_lane (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (en_i && hec_now_w),
    .lane_o (lane_w)
  );

  hec_byte_mux #(.W(W)) u_mux (
    .new_i     (new_w),
    .prev_i    (prev_w),
    .st_i      (st_w),
    .hec_i     (hec_i),
    .hec_now_i (hec_now_w),
    .lane_i    (lane_w),
    .word_o    (mux_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   word_q <= '0;
    else if (en_i) word_q <= mux_w;
  end

  assign word_o = word_q;
  assign jerk_o = jerk_w;
endmodule

// File: rtl/hec_slot_chk.sv
module hec_slot_chk #(
  parameter int CELL_WORDS = 13
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        en_i,
  input logic        jerk_o,
  input logic [31:0] word_o,
  input logic [5:0]  st_w,
  input logic        hec_now_w,
  input logic [1:0]  lane_w,
  input logic [31:0] new_w,
  input logic [31:0] prev_w
);
  localparam int GROUP_WORDS = 4 * CELL_WORDS + 1;
  localparam int GW_W        = $clog2(GROUP_WORDS + 1);

  logic [GW_W-1:0] gap_q;
  logic            seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (en_i) begin
      if (jerk_o) begin
        gap_q  <= '0;
        seen_q <= 1'b1;
      end else begin
        gap_q  <= gap_q + 1'b1;
      end
    end
  end

  p_state_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(st_w) == 1);

  p_jerk_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && jerk_o |=> !jerk_o);

  p_jerk_period_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && jerk_o && seen_q |-> gap_q == GW_W'(GROUP_WORDS - 1));

  p_idle_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(word_o) && $stable(st_w) && $stable(new_w));

  p_prev_follows_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !jerk_o |=> prev_w == $past(new_w));

  p_jerk_freeze_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && jerk_o |=> $stable(new_w) && $stable(prev_w));

  p_lane_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && hec_now_w |=> lane_w == $past(lane_w) + 2'd1);
endmodule

bind hec_slot_ins hec_slot_chk #(.CELL_WORDS(CELL_WORDS)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .en_i      (en_i),
  .jerk_o    (jerk_o),
  .word_o    (word_o),
  .st_w      (st_w),
  .hec_now_w (hec_now_w),
  .lane_w    (lane_w),
  .new_w     (new_w),
  .prev_w    (prev_w)
);

// File: tb/sim_hec_slot_ins.sv
`timescale 1ns/1ps
module sim_hec_slot_ins;
  localparam int CW = 13;
  localparam int GW = 4 * CW + 1;
  localparam int NG = 6;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        en_i;
  logic [31:0] data_i;
  logic [7:0]  hec_i;
  logic [31:0] word_o;
  logic        jerk_o;

  always #2.5 clk_i = ~clk_i;

  hec_slot_ins #(.CELL_WORDS(CW)) u0 (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .data_i (data_i),
    .hec_i  (hec_i),
    .word_o (word_o),
    .jerk_o (jerk_o)
  );

  logic [31:0] in_q[$];
  logic [7:0]  hq[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int          checks = 0;
  int          fails  = 0;
  bit          done   = 1'b0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, expv, $time);
    end
  endtask

  // driver side: build one group of four cells and its expected words
  task automatic push_group(int mode);
    logic [7:0] ib[208];
    logic [7:0] ob[212];
    logic [7:0] hc[4];
    for (int c = 0; c < 4; c++) begin
      hc[c] = (mode == 0) ? 8'(8'h10 + c) : (mode == 1) ? 8'h00 : 8'($urandom);
      for (int k = 0; k < 52; k++) begin
        case (mode)
          0:       ib[52*c+k] = 8'(52*c + k + 1);
          1:       ib[52*c+k] = 8'hFF;
          3:       ib[52*c+k] = k[0] ? 8'h5A : 8'hA5;
          default: ib[52*c+k] = 8'($urandom);
        endcase
      end
    end
    for (int w = 0; w < 52; w++) begin
      in_q.push_back({ib[4*w], ib[4*w+1], ib[4*w+2], ib[4*w+3]});
      hq.push_back(hc[w / CW]);
    end
    for (int c = 0; c < 4; c++) begin
      for (int k = 0; k < 4; k++)  ob[53*c+k]   = ib[52*c+k];
      ob[53*c+4] = hc[c];
      for (int k = 0; k < 48; k++) ob[53*c+5+k] = ib[52*c+4+k];
    end
    for (int j = 0; j < GW; j++) begin
      exp_q.push_back({ob[4*j], ob[4*j+1], ob[4*j+2], ob[4*j+3]});
      if (j == 0)                                   tag_q.push_back("R3");
      else if (j == 1 || j == 14 || j == 27 || j == 40) tag_q.push_back("R5");
      else if (j == 41)                             tag_q.push_back("R7");
      else if (j == 15 || j == 28)                  tag_q.push_back("R8");
      else                                          tag_q.push_back("R2");
    end
  endtask

  // monitor: pop and compare on every enabled edge
  initial begin
    logic [31:0] last_o;
    logic [31:0] e;
    string       t;
    last_o = '0;
    forever begin
      @(posedge clk_i);
      #1;
      if (done) break;
      if (rst_ni) begin
        if (en_i) begin
          if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(word_o == e, t, word_o, e);
          end
        end else begin
          chk(word_o == last_o, "R6", word_o, last_o);
        end
      end
      last_o = word_o;
    end
  end

  // driver
  initial begin
    int ecnt;
    bit jk;
    bit forced;
    ecnt   = 0;
    forced = 1'b0;
    rst_ni = 1'b0;
    en_i   = 1'b0;
    data_i = '0;
    hec_i  = '0;
    exp_q.push_back(32'h0);
    tag_q.push_back("R1");
    for (int g = 0; g < NG; g++) push_group(g);
    repeat (3) @(negedge clk_i);
    chk(word_o == 32'h0, "R1", word_o, 32'h0);
    chk(jerk_o == 1'b0, "R1", {31'h0, jerk_o}, 32'h0);
    rst_ni = 1'b1;
    while (exp_q.size() > 0) begin
      @(negedge clk_i);
      jk = jerk_o;
      chk(jk == ((ecnt % GW) == 41), "R4", {31'h0, jk}, {31'h0, ((ecnt % GW) == 41)});
      if (ecnt < 110)
        en_i = 1'b1;
      else if (!forced && ecnt == 200) begin
        en_i   = 1'b0;
        forced = 1'b1;
      end else
        en_i = (($urandom % 4) != 0);
      data_i = (in_q.size() > 0) ? in_q[0] : 32'h0;
      hec_i  = (hq.size() > 0) ? hq[0] : 8'h0;
      @(posedge clk_i);
      if (en_i) begin
        ecnt++;
        if (!jk && in_q.size() > 0) begin
          void'(in_q.pop_front());
          void'(hq.pop_front());
        end
      end
    end
    @(negedge clk_i);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    fails++;
    $display("FAIL R2 watchdog expired act=%0d exp=0 words left", exp_q.size());
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule